// File: doc/BRIEF.md
# Fuzzification Table Lookup Unit

This unit turns one crisp 8-bit measurement into a full set of fuzzy membership degrees using a single read of a precomputed table. Each crisp value owns one 32-bit table word. The unit computes that word's byte address by scaling the crisp value by four and adding a table base. It reads the word through a synchronous memory port with one cycle of latency. It then splits the word into two packed (set identifier, degree) pairs and spreads them over a sixteen-slot membership vector. Every slot that the word does not name reads zero.

A lookup begins when `start` is high while the unit is idle. `crisp_in` and `table_base` are sampled in that same cycle. The unit raises `busy` for three cycles. In the first of those cycles it issues one read. It captures the returned word in the next cycle. In the third cycle it pulses `result_valid` and presents the new vector. The vector then stays unchanged until the next lookup completes. The host is expected to build the table in memory beforehand. Rule inference and defuzzification happen downstream of this unit.

Top module: `fz_lookup`

## Requirements
- R1: While reset is high and in the cycle after it falls, `busy`, `mem_rd_en` and `result_valid` are 0 and every membership slot is 0.
- R2: In the read cycle, `mem_addr` equals `table_base + 4*crisp_in` modulo 2^16, using the values sampled when the start was accepted.
- R3: Each accepted start produces exactly one read. `mem_rd_en` is high for a single cycle, and that cycle is the one right after acceptance.
- R4: `result_valid` is high for exactly one cycle, two cycles after the read cycle. `busy` is high from the read cycle through that result cycle.
- R5: The table word holds two pairs. The low half has its identifier in bits [11:8] and its degree in bits [7:0]. The high half has its identifier in bits [27:24] and its degree in bits [23:16]. Set s appears in `membership[8*s+7:8*s]`.
- R6: Every set identifier that neither half of the word names gets a degree of 0.
- R7: When both halves name the same identifier, that slot receives the larger of the two degrees.
- R8: The reserved bits [15:12] and [31:28] of the word have no effect on the result.
- R9: A start raised while `busy` is high is ignored. It causes no extra read and no extra result, and it does not change the lookup already in progress.
- R10: The membership vector changes only in a cycle where `result_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Requests a lookup; accepted only while idle |
| crisp_in | input | 8 | Crisp input value, sampled on acceptance |
| table_base | input | 16 | Byte address of the table start, sampled on acceptance |
| busy | output | 1 | High while a lookup is in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Byte address of the table word |
| mem_rd_data | input | 32 | Table word, valid one cycle after the read strobe |
| result_valid | output | 1 | One-cycle pulse marking a new membership vector |
| membership | output | 128 | Sixteen 8-bit degrees, set s in bits [8s+7:8s] |

## Verification
If the sequencer lands in a wrong state, the fault appears at the ports within two or three cycles. It shows up as a missing or repeated read strobe, a result pulse at the wrong distance from the read, or a second read caused by a start sent while busy. A wrong captured index or base shows up as a wrong `mem_addr` in the very read cycle; the table vectors include an address that wraps past the top of the space. Faults in the expansion show up in the `result_valid` cycle as a misplaced or leftover degree. The vectors for this include duplicate identifiers, reserved bits that are set, and a word read while the held vector stays unchanged.

// File: rtl/fz_pkg.sv
package fz_pkg;

    localparam int CRISP_W  = 8;
    localparam int DEG_W    = 8;
    localparam int ID_W     = 4;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int NUM_SETS = 1 << ID_W;
    localparam int PAIRS    = WORD_W / HALF_W;
    localparam int SCALE_SH = 2;
    localparam int VEC_W    = NUM_SETS * DEG_W;

    typedef logic [ID_W-1:0]  set_id_t;
    typedef logic [DEG_W-1:0] deg_t;

    typedef struct packed {
        set_id_t id;
        deg_t    deg;
    } fz_pair_t;

    typedef enum logic [1:0] {
        FZ_IDLE = 2'd0,
        FZ_READ = 2'd1,
        FZ_WAIT = 2'd2,
        FZ_DONE = 2'd3
    } fz_state_e;

    function automatic fz_pair_t split_half(input logic [HALF_W-1:0] h);
        fz_pair_t p;
        p.id  = h[DEG_W +: ID_W];
        p.deg = h[DEG_W-1:0];
        return p;
    endfunction

    function automatic deg_t deg_max(input deg_t a, input deg_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fz_addr_gen.sv
module fz_addr_gen
    import fz_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [CRISP_W-1:0] crisp_in,
    input  logic [ADDR_W-1:0]  table_base,
    output logic [ADDR_W-1:0]  mem_addr
);
    localparam int OFS_W = CRISP_W + SCALE_SH;

    logic [CRISP_W-1:0] crisp_q;
    logic [ADDR_W-1:0]  base_q;
    logic [OFS_W-1:0]   byte_ofs;

    always_ff @(posedge clk) begin
        if (rst) begin
            crisp_q <= '0;
            base_q  <= '0;
        end else if (accept) begin
            crisp_q <= crisp_in;
            base_q  <= table_base;
        end
    end

    always_comb begin
        byte_ofs = {crisp_q, {SCALE_SH{1'b0}}};
        mem_addr = base_q + ADDR_W'(byte_ofs);
    end

endmodule

// File: rtl/fz_ctrl.sv
module fz_ctrl
    import fz_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic rd_en,
    output logic capture,
    output logic done
);
    fz_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FZ_IDLE: if (start) state_d = FZ_READ;
            FZ_READ: state_d = FZ_WAIT;
            FZ_WAIT: state_d = FZ_DONE;
            FZ_DONE: state_d = FZ_IDLE;
            default: state_d = FZ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FZ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        accept  = start && (state_q == FZ_IDLE);
        busy    = (state_q != FZ_IDLE);
        rd_en   = (state_q == FZ_READ);
        capture = (state_q == FZ_WAIT);
        done    = (state_q == FZ_DONE);
    end

endmodule

// File: rtl/fz_expand.sv
module fz_expand
    import fz_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [VEC_W-1:0]  vec
);
    fz_pair_t pairs [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pairs[p] = split_half(word[p*HALF_W +: HALF_W]);
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_comb begin
            deg_t acc;
            acc = '0;
            for (int p = 0; p < PAIRS; p++) begin
                if (pairs[p].id == set_id_t'(s)) acc = deg_max(acc, pairs[p].deg);
            end
            vec[s*DEG_W +: DEG_W] = acc;
        end
    end

endmodule

// File: rtl/fz_lookup.sv
module fz_lookup
    import fz_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CRISP_W-1:0] crisp_in,
    input  logic [ADDR_W-1:0]  table_base,
    output logic               busy,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               result_valid,
    output logic [VEC_W-1:0]   membership
);
    logic             accept, capture, done;
    logic [VEC_W-1:0] vec_next;
    logic [VEC_W-1:0] vec_q;

    fz_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .accept  (accept),
        .busy    (busy),
        .rd_en   (mem_rd_en),
        .capture (capture),
        .done    (done)
    );

    fz_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .crisp_in   (crisp_in),
        .table_base (table_base),
        .mem_addr   (mem_addr)
    );

    fz_expand u_expand (
        .word (mem_rd_data),
        .vec  (vec_next)
    );

    always_ff @(posedge clk) begin
        if (rst)          vec_q <= '0;
        else if (capture) vec_q <= vec_next;
    end

    assign membership   = vec_q;
    assign result_valid = done;

endmodule

// File: rtl/fz_lookup_chk.sv
module fz_lookup_chk
    import fz_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [CRISP_W-1:0] crisp_in,
    input logic [ADDR_W-1:0]  table_base,
    input logic               busy,
    input logic               mem_rd_en,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               result_valid,
    input logic [VEC_W-1:0]   membership
);
    int nz_cnt;
    always_comb begin
        nz_cnt = 0;
        for (int s = 0; s < NUM_SETS; s++)
            if (membership[s*DEG_W +: DEG_W] != '0) nz_cnt++;
    end

    // R2
    read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> mem_addr == ADDR_W'($past(table_base) +
                                          ADDR_W'({$past(crisp_in), 2'b00})));

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R3
    read_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> mem_rd_en);

    // R4
    result_timing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ##2 result_valid);

    // R4
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R9
    no_busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> $rose(busy));

    // R6
    sparse_vec_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> nz_cnt <= 2);

    // R10
    hold_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(membership));

endmodule

bind fz_lookup fz_lookup_chk #(.ADDR_W(ADDR_W)) u_fz_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .crisp_in     (crisp_in),
    .table_base   (table_base),
    .busy         (busy),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .result_valid (result_valid),
    .membership   (membership)
);

// File: tb/tb_fz_lookup.sv
module tb_fz_lookup;
    localparam int NV = 7;
    // each vector: {base[55:40], crisp[39:32], word[31:0]}
    localparam logic [55:0] VECS [NV] = '{
        {16'h0000, 8'h00, 32'h0120_0380},
        {16'h1000, 8'hFF, 32'h0F11_00FF},
        {16'hFFF0, 8'h08, 32'h0590_0540},
        {16'h2400, 8'h37, 32'hF3C8_F2AB},
        {16'h0100, 8'h80, 32'h0700_0A00},
        {16'hABCC, 8'h01, 32'h0C7F_0C7F},
        {16'h0002, 8'h7E, 32'h0E01_0D02}
    };

    logic         clk = 0;
    logic         rst = 1;
    logic         start = 0;
    logic [7:0]   crisp_in = 0;
    logic [15:0]  table_base = 0;
    logic         busy, mem_rd_en, result_valid;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_rd_data = 0;
    logic [127:0] membership;
    logic [31:0]  mem_word = 0;
    int           rd_count = 0;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           finished = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem_word;
            rd_count    <= rd_count + 1;
        end
    end

    fz_lookup dut (
        .clk(clk), .rst(rst), .start(start), .crisp_in(crisp_in),
        .table_base(table_base), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .result_valid(result_valid), .membership(membership)
    );

    function automatic logic [127:0] expect_vec(input logic [31:0] w);
        logic [127:0] v = '0;
        for (int s = 0; s < 16; s++) begin
            logic [7:0] e = 8'h00;
            if (w[11:8] == 4'(s)) e = w[7:0];
            if (w[27:24] == 4'(s) && w[23:16] > e) e = w[23:16];
            v[s*8 +: 8] = e;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [15:0] base, input logic [7:0] crisp, input logic [31:0] w);
        int rc0;
        rc0 = rd_count;
        @(negedge clk);
        start = 1; crisp_in = crisp; table_base = base; mem_word = w;
        @(negedge clk);
        start = 0; crisp_in = ~crisp; table_base = ~base;
        check("R3 read strobe", 128'(mem_rd_en), 128'(1));
        check("R2 address", 128'(mem_addr), 128'(16'(base + {crisp, 2'b00})));
        @(negedge clk);
        check("R4 busy/no early result", 128'({busy, result_valid, mem_rd_en}), 128'(3'b100));
        @(negedge clk);
        check("R4 result pulse", 128'({busy, result_valid}), 128'(2'b11));
        check("R5 R6 R7 R8 vector", membership, expect_vec(w));
        @(negedge clk);
        check("R4 pulse ends", 128'({busy, result_valid}), 128'(0));
        check("R3 one read", 128'(rd_count - rc0), 128'(1));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        int rc0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 in reset", {membership[124:0], busy, mem_rd_en, result_valid}, 128'(0));
        rst = 0;
        @(negedge clk);
        check("R1 after reset", {membership[124:0], busy, mem_rd_en, result_valid}, 128'(0));
        check("R1 vector top", 128'(membership[127:125]), 128'(0));

        for (int i = 0; i < NV; i++)
            lookup(VECS[i][55:40], VECS[i][39:32], VECS[i][31:0]);

        // R9: start while busy is ignored
        rc0 = rd_count;
        @(negedge clk);
        start = 1; crisp_in = 8'h10; table_base = 16'h0200; mem_word = 32'h0366_0955;
        @(negedge clk);
        crisp_in = 8'h20; table_base = 16'h4000;
        check("R9 addr kept", 128'(mem_addr), 128'(16'h0240));
        @(negedge clk);
        crisp_in = 8'h30;
        check("R9 no read while busy", 128'(mem_rd_en), 128'(0));
        @(negedge clk);
        mem_word = 32'h0000_0000;
        check("R9 result of first", membership, expect_vec(32'h0366_0955));
        start = 0;
        @(negedge clk);
        @(negedge clk);
        check("R9 single read", 128'(rd_count - rc0), 128'(1));
        check("R9 no extra result", 128'({result_valid, mem_rd_en}), 128'(0));

        // R10: vector held while idle and while memory data changes
        held = membership;
        mem_word = 32'h0BFF_0AFF;
        repeat (5) @(negedge clk);
        check("R10 hold idle", membership, held);
        lookup(16'h0300, 8'h05, 32'h0BFF_0AFF);
        check("R10 replaced", membership, expect_vec(32'h0BFF_0AFF));

        // R6 zero word
        lookup(16'h0000, 8'h01, 32'h0000_0000);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule